// File: doc/BRIEF.md
# Prescaled Multi-Channel Timer Bank with PWM

A bank of identical 16-bit counting channels sits behind a single-cycle register port. Each channel has its own prescaler, count register, reload value, compare value and interrupt status. Software picks one of three behaviours per channel: a free-running counter that wraps at the ends of its range, a periodic counter that reloads itself and raises a tick interrupt, or a PWM generator whose duty cycle comes from the compare value.

The running count is only ever moved by the channel's own ticks. No register write places a value in it. The offset at 0x08 takes the reload value when written and gives the live count when read, so a periodic channel's first expiry comes at whatever point the count happens to hold. Each channel drives its own interrupt line and its own PWM pin.

Top module: `tmr_bank`

## Requirements
- R1: After reset every readable register of every channel is zero, and all interrupt and PWM outputs are low.
- R2: Channel n is decoded at byte offset n*0x20. Within a channel the control register sits at 0x00 and reads back bits 11:0. The prescaler sits at 0x04, the interrupt status at 0x0C (bit 0) and the compare value at 0x10. Any other offset, and any channel index of NUM_CH or more, reads as zero and ignores writes.
- R3: While enabled (control bit 0), a channel advances its count once every PSR+1 clock cycles, where PSR is the value held at offset 0x04.
- R4: Mode 0 (control bits 11:10 = 0) with the up bit (bit 4) set counts from 0 to 0xFFFF and wraps to 0. The tick that performs the wrap sets the status bit.
- R5: Mode 1 with bit 4 clear counts down. On the tick in which the count is 0, the channel loads the reload value and sets the status bit.
- R6: A write to offset 0x08 changes only the reload value and never the count. A read of 0x08 returns the count.
- R7: Writing zero to the control register halts the channel, and the count then holds its value.
- R8: Writing zero to the status offset clears the status bit. A nonzero write leaves it unchanged.
- R9: A channel's interrupt line is high exactly when its status bit and its interrupt-enable bit (bit 1) are both set. The status bit still latches while the interrupt is disabled.
- R10: Mode 2 with the up bit set counts 0..reload and wraps. With PWM-on (bit 3) and output-enable (bit 2) set, the PWM pin is high while count < compare and low otherwise. Output-mode bit 6 inverts that level.
- R11: The PWM pin is low whenever the mode is not 2, or PWM-on or output-enable is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the same cycle as the access |
| irq | output | NUM_CH | Per-channel interrupt |
| pwm_out | output | NUM_CH | Per-channel PWM pin |

## Verification
The bench runs a full 16-bit wrap. A design that wrapped one count early, or set status on the wrong tick, shows the interrupt one cycle off. It checks the periodic reload from a count that starts at zero, which must expire on the very first tick. It also checks that a nonzero status write does not act as a clear.

The count is read back after writes to the reload offset and after a halt, so a design that let software touch the count is caught. PWM level and polarity are compared against the count read at the same instant. This exposes off-by-one compare edges and a reload period one tick too long or too short.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int unsigned WIN_LOG2 = 5;
   localparam logic [WIN_LOG2-1:0] OFF_CTRL = 5'h00;
   localparam logic [WIN_LOG2-1:0] OFF_PSC  = 5'h04;
   localparam logic [WIN_LOG2-1:0] OFF_LOAD = 5'h08;
   localparam logic [WIN_LOG2-1:0] OFF_STAT = 5'h0C;
   localparam logic [WIN_LOG2-1:0] OFF_CMP  = 5'h10;
   localparam int unsigned CTRL_W = 12;

   typedef enum logic [1:0] {
      MODE_FREE     = 2'd0,
      MODE_PERIODIC = 2'd1,
      MODE_PWM      = 2'd2,
      MODE_SPARE    = 2'd3
   } tmr_mode_e;

   typedef struct packed {
      tmr_mode_e  mode;      // 11:10
      logic [1:0] edge_sel;  // 9:8 stored only
      logic       spare;     // 7 reads zero
      logic       inv;       // 6 output polarity
      logic       dir_src;   // 5 stored only
      logic       up;        // 4
      logic       pwm_on;    // 3
      logic       oe;        // 2
      logic       ie;        // 1
      logic       en;        // 0
   } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] phase_q;

   // >= so that lowering the divider mid-period cannot strand the phase
   assign tick = en && (phase_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= '0;
      end else if (!en || tick) begin
         phase_q <= '0;
      end else begin
         phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmr_mode_e        mode,
   input  logic             up,
   input  logic [CNT_W-1:0] reload,
   input  logic             clr_stat,
   output logic [CNT_W-1:0] cnt,
   output logic             stat
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic             reloading;
   logic             expire;
   logic [CNT_W-1:0] cnt_nxt;

   always_comb begin
      reloading = (mode == MODE_PERIODIC) || (mode == MODE_PWM);
      if (up) begin
         expire  = (cnt == (reloading ? reload : CNT_TOP));
         cnt_nxt = expire ? '0 : cnt + 1'b1;
      end else begin
         expire  = (cnt == '0);
         cnt_nxt = expire ? (reloading ? reload : CNT_TOP) : cnt - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         stat <= 1'b0;
      end else begin
         if (tick) begin
            cnt <= cnt_nxt;
         end
         // a new expiry wins over a clear in the same cycle
         if (tick && expire) begin
            stat <= 1'b1;
         end else if (clr_stat) begin
            stat <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tmr_ctrl_t        ctrl,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cmp,
   output logic             pin
);
   logic active;
   logic level;

   assign active = (ctrl.mode == MODE_PWM) && ctrl.pwm_on && ctrl.oe;
   assign level  = active && ((cnt < cmp) ^ ctrl.inv);

   if (REG_OUT) begin : g_flop
      logic pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= 1'b0;
         else        pin_q <= level;
      end
      assign pin = pin_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign pin = level;
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PSC_W   = 16,
   parameter int unsigned DATA_W  = 32,
   parameter bit          REG_PWM = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WIN_LOG2-1:0] off,
   input  logic [DATA_W-1:0]   wdata,
   output logic [DATA_W-1:0]   rdata,
   output logic                irq,
   output logic                pwm,
   output logic                tick,
   output tmr_ctrl_t           ctrl,
   output logic [CNT_W-1:0]    cnt,
   output logic [CNT_W-1:0]    reload,
   output logic [PSC_W-1:0]    psr,
   output logic                stat
);
   logic [CNT_W-1:0] cmp_q;
   logic             clr_stat;

   assign clr_stat = wr_en && (off == OFF_STAT) && (wdata == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= '0;
         psr    <= '0;
         reload <= '0;
         cmp_q  <= '0;
      end else if (wr_en) begin
         unique case (off)
            OFF_CTRL: begin
               ctrl       <= tmr_ctrl_t'(wdata[CTRL_W-1:0]);
               ctrl.spare <= 1'b0;
            end
            OFF_PSC:  psr    <= wdata[PSC_W-1:0];
            OFF_LOAD: reload <= wdata[CNT_W-1:0];
            OFF_CMP:  cmp_q  <= wdata[CNT_W-1:0];
            default: ;
         endcase
      end
   end

   tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ctrl.en),
      .div  (psr),
      .tick (tick)
   );

   tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .mode    (ctrl.mode),
      .up      (ctrl.up),
      .reload  (reload),
      .clr_stat(clr_stat),
      .cnt     (cnt),
      .stat    (stat)
   );

   tmr_pwm #(.CNT_W(CNT_W), .REG_OUT(REG_PWM)) u_pwm (
      .clk  (clk),
      .rst_n(rst_n),
      .ctrl (ctrl),
      .cnt  (cnt),
      .cmp  (cmp_q),
      .pin  (pwm)
   );

   assign irq = stat & ctrl.ie;

   always_comb begin
      rdata = '0;
      unique case (off)
         OFF_CTRL: rdata = DATA_W'(ctrl);
         OFF_PSC:  rdata = DATA_W'(psr);
         OFF_LOAD: rdata = DATA_W'(cnt);
         OFF_STAT: rdata = DATA_W'(stat);
         OFF_CMP:  rdata = DATA_W'(cmp_q);
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH  = 5,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PSC_W   = 16,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter bit          REG_PWM = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int unsigned IDX_W = ADDR_W - WIN_LOG2;

   if (ADDR_W <= WIN_LOG2) begin : g_bad_addr
      $error("ADDR_W leaves no channel index bits");
   end
   if ((NUM_CH << WIN_LOG2) > (1 << ADDR_W)) begin : g_bad_span
      $error("NUM_CH windows do not fit in ADDR_W");
   end
   if (CNT_W > DATA_W || PSC_W > DATA_W || CTRL_W > DATA_W) begin : g_bad_width
      $error("register field wider than DATA_W");
   end
   if (NUM_CH == 0) begin : g_bad_num
      $error("NUM_CH must be at least one");
   end

   logic [IDX_W-1:0]    ch_idx;
   logic [WIN_LOG2-1:0] ch_off;
   logic [DATA_W-1:0]   ch_rd   [NUM_CH];
   logic [NUM_CH-1:0]   ch_tick;
   logic [NUM_CH-1:0]   ch_stat;
   tmr_ctrl_t           ch_ctrl [NUM_CH];
   logic [CNT_W-1:0]    ch_cnt  [NUM_CH];
   logic [CNT_W-1:0]    ch_load [NUM_CH];
   logic [PSC_W-1:0]    ch_psr  [NUM_CH];

   assign ch_idx = bus_addr[ADDR_W-1:WIN_LOG2];
   assign ch_off = bus_addr[WIN_LOG2-1:0];

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel_wr;
      assign sel_wr = bus_sel && bus_wr && (ch_idx == IDX_W'(i));

      tmr_channel #(
         .CNT_W  (CNT_W),
         .PSC_W  (PSC_W),
         .DATA_W (DATA_W),
         .REG_PWM(REG_PWM)
      ) u_ch (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (sel_wr),
         .off   (ch_off),
         .wdata (bus_wdata),
         .rdata (ch_rd[i]),
         .irq   (irq[i]),
         .pwm   (pwm_out[i]),
         .tick  (ch_tick[i]),
         .ctrl  (ch_ctrl[i]),
         .cnt   (ch_cnt[i]),
         .reload(ch_load[i]),
         .psr   (ch_psr[i]),
         .stat  (ch_stat[i])
      );
   end

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (bus_sel && (ch_idx == IDX_W'(i))) begin
            bus_rdata = ch_rd[i];
         end
      end
   end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk
   import tmr_pkg::*;
#(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PSC_W  = 16,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] ch_tick,
   input logic [NUM_CH-1:0] ch_stat,
   input tmr_ctrl_t         ch_ctrl [NUM_CH],
   input logic [CNT_W-1:0]  ch_cnt  [NUM_CH],
   input logic [CNT_W-1:0]  ch_load [NUM_CH],
   input logic [PSC_W-1:0]  ch_psr  [NUM_CH]
);
   localparam logic [CNT_W-1:0] TOP = '1;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
      logic zero_stat_wr;
      assign zero_stat_wr = bus_sel && bus_wr &&
                            (bus_addr[ADDR_W-1:WIN_LOG2] == (ADDR_W-WIN_LOG2)'(i)) &&
                            (bus_addr[WIN_LOG2-1:0] == OFF_STAT) && (bus_wdata == '0);

      p_prescale_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ch_tick[i] |=> (!ch_tick[i] || ch_psr[i] == '0));

      p_wrap_sets_stat_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_tick[i] && ch_ctrl[i].mode == MODE_FREE && ch_ctrl[i].up && ch_cnt[i] == TOP)
         |=> (ch_cnt[i] == '0 && ch_stat[i]));

      p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_tick[i] && ch_ctrl[i].mode == MODE_PERIODIC && !ch_ctrl[i].up && ch_cnt[i] == '0)
         |=> (ch_cnt[i] == $past(ch_load[i]) && ch_stat[i]));

      p_count_only_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_tick[i] |=> $stable(ch_cnt[i]));

      p_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
         !ch_ctrl[i].en |=> $stable(ch_cnt[i]));

      p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (zero_stat_wr && !ch_tick[i]) |=> !ch_stat[i]);

      p_pwm_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_ctrl[i].mode != MODE_PWM || !ch_ctrl[i].oe) |-> !pwm_out[i]);
   end
endmodule

bind tmr_bank tmr_bank_chk #(
   .NUM_CH(NUM_CH),
   .CNT_W (CNT_W),
   .PSC_W (PSC_W),
   .DATA_W(DATA_W),
   .ADDR_W(ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_sel  (bus_sel),
   .bus_wr   (bus_wr),
   .bus_addr (bus_addr),
   .bus_wdata(bus_wdata),
   .pwm_out  (pwm_out),
   .ch_tick  (ch_tick),
   .ch_stat  (ch_stat),
   .ch_ctrl  (ch_ctrl),
   .ch_cnt   (ch_cnt),
   .ch_load  (ch_load),
   .ch_psr   (ch_psr)
);

// File: tb/tmr_bank_tb.sv
module tmr_bank_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 5;
   localparam int ADDR_W = 8;
   localparam int DATA_W = 32;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [DATA_W-1:0] bus_wdata = '0;
   logic [DATA_W-1:0] bus_rdata;
   logic [NUM_CH-1:0] irq;
   logic [NUM_CH-1:0] pwm_out;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_bank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .pwm_out(pwm_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input int ch, input logic [4:0] off, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1;
      bus_addr = ADDR_W'(ch * 32) | ADDR_W'(off);
      bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int ch, input logic [4:0] off, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0;
      bus_addr = ADDR_W'(ch * 32) | ADDR_W'(off);
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int c = 0; c < NUM_CH; c++) begin
         for (int o = 0; o < 5; o++) begin
            rd(c, 5'(o * 4), v);
            check("R1 reset register", v, 0);
         end
      end
      check("R1 irq at reset", 32'(irq), 0);
      check("R1 pwm at reset", 32'(pwm_out), 0);
   endtask

   task automatic t_freerun_halt_load();
      logic [31:0] v;
      wr(0, 5'h00, 32'h11);
      idle(10);
      rd(0, 5'h08, v); check("R4 free-run up count", v, 10);
      wr(0, 5'h00, 0);
      rd(0, 5'h08, v); check("R7 count at halt", v, 11);
      idle(5);
      rd(0, 5'h08, v); check("R7 count held while halted", v, 11);
      wr(0, 5'h08, 32'h1234);
      rd(0, 5'h08, v); check("R6 reload write leaves count", v, 11);
   endtask

   task automatic t_prescale_decode();
      logic [31:0] v;
      wr(1, 5'h04, 3);
      wr(1, 5'h00, 32'h11);
      idle(20);
      rd(1, 5'h08, v); check("R3 count with PSR=3", v, 5);
      rd(1, 5'h04, v); check("R2 prescaler readback", v, 3);
      rd(1, 5'h00, v); check("R2 control readback", v, 32'h11);
      wr(1, 5'h10, 32'hBEEF);
      rd(1, 5'h10, v); check("R2 compare readback", v, 32'hBEEF);
      rd(1, 5'h14, v); check("R2 unused offset", v, 0);
      wr(5, 5'h00, 32'hFFF);
      rd(5, 5'h00, v); check("R2 channel beyond bank", v, 0);
   endtask

   task automatic t_periodic();
      logic [31:0] v;
      wr(2, 5'h08, 4);
      wr(2, 5'h00, 32'h403);
      idle(1);
      rd(2, 5'h08, v); check("R5 first expiry reloads", v, 4);
      check("R9 irq after expiry", 32'(irq[2]), 1);
      wr(2, 5'h0C, 0);
      rd(2, 5'h08, v); check("R5 count after reload", v, 3);
      check("R8 zero write clears", 32'(irq[2]), 0);
      idle(3);
      rd(2, 5'h08, v); check("R5 reached zero", v, 0);
      check("R5 no irq before expiry", 32'(irq[2]), 0);
      idle(1);
      rd(2, 5'h08, v); check("R5 second reload", v, 4);
      check("R5 irq on second expiry", 32'(irq[2]), 1);
      wr(2, 5'h0C, 1);
      rd(2, 5'h0C, v); check("R8 nonzero write ignored", v, 1);
      wr(2, 5'h0C, 0);
      check("R8 cleared", 32'(irq[2]), 0);
      wr(2, 5'h00, 32'h401);
      idle(2);
      rd(2, 5'h0C, v); check("R9 status latches with ie clear", v, 1);
      check("R9 irq masked", 32'(irq[2]), 0);
   endtask

   task automatic t_wrap();
      logic [31:0] v;
      wr(3, 5'h00, 32'h13);
      idle(65535);
      rd(3, 5'h08, v); check("R4 top of range", v, 32'hFFFF);
      check("R4 no irq before wrap", 32'(irq[3]), 0);
      idle(1);
      rd(3, 5'h08, v); check("R4 wrapped to zero", v, 0);
      check("R4 irq on wrap", 32'(irq[3]), 1);
   endtask

   task automatic t_pwm();
      logic [31:0] v;
      wr(4, 5'h08, 9);
      wr(4, 5'h10, 3);
      wr(4, 5'h00, 32'h81D);
      for (int k = 0; k < 20; k++) begin
         rd(4, 5'h08, v);
         check("R10 pwm period count", v, 32'(k % 10));
         check("R10 pwm level", 32'(pwm_out[4]), 32'(k % 10 < 3));
         idle(1);
      end
      rd(4, 5'h0C, v); check("R9 pwm status latched", v, 1);
      check("R9 pwm irq masked", 32'(irq[4]), 0);
      wr(4, 5'h00, 32'h85D);
      for (int k = 0; k < 10; k++) begin
         rd(4, 5'h08, v);
         check("R10 inverted level", 32'(pwm_out[4]), 32'(!(v < 3)));
         idle(1);
      end
      wr(4, 5'h00, 32'h815);
      for (int k = 0; k < 5; k++) begin
         check("R11 pwm-on clear keeps pin low", 32'(pwm_out[4]), 0);
         idle(1);
      end
      wr(4, 5'h00, 32'h41D);
      for (int k = 0; k < 5; k++) begin
         check("R11 mode 1 keeps pin low", 32'(pwm_out[4]), 0);
         idle(1);
      end
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_freerun_halt_load();
      t_prescale_decode();
      t_periodic();
      t_pwm();
      t_wrap();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule